// File: doc/BRIEF.md
# Startup Capture Sample Viewer

This block records the first few words that appear on a fast data bus, beginning with the very first clock cycle after reset is released. It does not wait for a trigger. It writes those words into a small on-chip sample store and then freezes them. From then on it drives one stored word at a time onto a parallel output, so that a slow observer such as a row of LEDs can read it. The input can be running at the full clock rate, far too fast to watch directly.

A single-cycle step pulse moves the view to the next stored word. After the last word, the view wraps round to the first. The block also outputs the index of the word on display, so that a checker or a person can tie each shown value to the cycle it was taken in. The data width `W` and the number of samples `S` are parameters. `S` must be at least 2; for example, `S=2, W=2` and `S=4, W=8` are both valid.

Top module: `ssv_startup_viewer`

## Requirements
- R1: While `rst` is high at a rising edge, `view_idx` becomes 0 at that edge.
- R2: The first rising edge with `rst` low is capture cycle 0. Stored sample k is the value of `data_in` at capture cycle k, for k = 0 to S-1.
- R3: Exactly S samples are captured. After capture cycle S-1 the stored samples do not change while `data_in` keeps changing, until the next reset.
- R4: At the first falling edge after capture cycle S-1, `view_idx` is 0 and `sample_out` equals stored sample 0.
- R5: Once capture is complete, each rising edge with `step` high increases `view_idx` by one. At that same edge, `sample_out` takes the stored sample at the new index.
- R6: A step while `view_idx` equals S-1 sets `view_idx` to 0 and `sample_out` to sample 0.
- R7: A `step` that stays high for several cycles advances the view once for each high cycle.
- R8: A `step` that is high at any edge up to and including capture cycle S-1 is ignored, and `view_idx` stays 0.
- R9: Reset overrides a simultaneous step. After reset is released, a new capture starts at capture cycle 0 and overwrites every stored sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | W | Bus being recorded |
| step | input | 1 | Advance-view pulse, one advance per high cycle |
| sample_out | output | W | Registered stored sample at the current view index |
| view_idx | output | ceil(log2(S)) | Index of the sample on display |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a step pulse and the final capture write share capture cycle S-1. The bench holds `step` high through the whole capture window and then expects the view to sit at index 0 and show sample 0. In the second, a step pulse and a reset share an edge. The bench raises both together and expects index 0, followed by a fresh capture of new data. Between these collisions, repeated wrap-around sweeps and multi-cycle step pulses compare each displayed word against the stimulus that the bench computes arithmetically for that capture cycle.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
  // Width of an index that addresses s entries (never below 1 bit).
  function automatic int idx_bits(input int s);
    return (s <= 2) ? 1 : $clog2(s);
  endfunction

  // Width of a counter that must reach the value s itself.
  function automatic int cnt_bits(input int s);
    return $clog2(s + 1);
  endfunction
endpackage

// File: rtl/ssv_capture_ctrl.sv
module ssv_capture_ctrl #(
  parameter int S  = 4,
  parameter int IW = ssv_pkg::idx_bits(S)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          wr_en,
  output logic [IW-1:0] wr_addr,
  output logic          done
);
  localparam int CW = ssv_pkg::cnt_bits(S);
  localparam logic [CW-1:0] FULL = CW'(S);

  logic [CW-1:0] cap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_cnt <= '0;
    end else if (cap_cnt != FULL) begin
      cap_cnt <= cap_cnt + 1'b1;
    end
  end

  assign done    = (cap_cnt == FULL);
  assign wr_en   = !done && !rst;
  assign wr_addr = cap_cnt[IW-1:0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cap_cnt <= FULL); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R3
  AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != IW'(S-1)) |=> (wr_en && wr_addr == $past(wr_addr) + 1'b1)); // R2
endmodule

// File: rtl/ssv_sample_mem.sv
module ssv_sample_mem #(
  parameter int W  = 8,
  parameter int S  = 4,
  parameter int IW = ssv_pkg::idx_bits(S)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] store [S];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
    rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/ssv_view_index.sv
module ssv_view_index #(
  parameter int S  = 4,
  parameter int IW = ssv_pkg::idx_bits(S)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          armed,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] idx_nxt
);
  localparam logic [IW-1:0] LAST = IW'(S-1);

  always_comb begin
    idx_nxt = idx;
    if (rst) begin
      idx_nxt = '0;
    end else if (armed && step) begin
      idx_nxt = (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    idx <= idx_nxt;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST); // R6
  AST_HOLD_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !armed |=> $stable(idx)); // R8
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (rst)
    (armed && step && idx != LAST) |=> idx == $past(idx) + 1'b1); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (armed && step && idx == LAST) |=> idx == '0); // R6
endmodule

// File: rtl/ssv_startup_viewer.sv
module ssv_startup_viewer #(
  parameter int W  = 8,
  parameter int S  = 4,
  parameter int IW = ssv_pkg::idx_bits(S)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  data_in,
  input  logic          step,
  output logic [W-1:0]  sample_out,
  output logic [IW-1:0] view_idx
);
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic          cap_done;
  logic [IW-1:0] idx_nxt;

  ssv_capture_ctrl #(.S(S), .IW(IW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .done    (cap_done)
  );

  ssv_view_index #(.S(S), .IW(IW)) u_view (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .armed   (cap_done),
    .idx     (view_idx),
    .idx_nxt (idx_nxt)
  );

  // Read address is the index of the coming cycle, so data and index move together.
  ssv_sample_mem #(.W(W), .S(S), .IW(IW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (data_in),
    .rd_addr (idx_nxt),
    .rd_data (sample_out)
  );

  AST_RST_IDX: assert property (@(posedge clk)
    rst |=> view_idx == '0); // R1
  AST_NO_WRITE_DONE: assert property (@(posedge clk) disable iff (rst)
    cap_done |-> !wr_en); // R3
endmodule

// File: tb/ssv_startup_viewer_tb.sv
module ssv_startup_viewer_tb;
  localparam int W  = 8;
  localparam int S  = 4;
  localparam int IW = ssv_pkg::idx_bits(S);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  data_in = '0;
  logic          step = 1'b0;
  logic [W-1:0]  sample_out;
  logic [IW-1:0] view_idx;

  int total = 0;
  int bad = 0;
  int cur_round = 0;

  always #10 clk = ~clk;

  ssv_startup_viewer #(.W(W), .S(S)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .data_in    (data_in),
    .step       (step),
    .sample_out (sample_out),
    .view_idx   (view_idx)
  );

  function automatic logic [W-1:0] stim(input int round, input int k);
    return W'((k * 37 + round * 53 + 5) % 256);
  endfunction

  task automatic check_view(input string req, input int exp_idx, input int round);
    total++;
    if (view_idx != IW'(exp_idx) || sample_out != stim(round, exp_idx)) begin
      bad++;
      $display("FAIL %s: idx=%0d data=%0h expected idx=%0d data=%0h",
               req, view_idx, sample_out, exp_idx, stim(round, exp_idx));
    end
  endtask

  task automatic check_idx(input string req, input int exp_idx);
    total++;
    if (view_idx != IW'(exp_idx)) begin
      bad++;
      $display("FAIL %s: idx=%0d expected idx=%0d", req, view_idx, exp_idx);
    end
  endtask

  // Reset, then capture S words; step_during holds step high through the window.
  task automatic capture_round(input int round, input bit step_during);
    @(negedge clk);
    rst = 1'b1;
    step = 1'b0;
    repeat (3) @(negedge clk);
    check_idx("R1", 0);
    rst = 1'b0;
    step = step_during;
    for (int k = 0; k < S; k++) begin
      data_in = stim(round, k);
      @(negedge clk);
    end
    step = 1'b0;
    data_in = ~stim(round, 0);
    check_view("R4 R2 R8", 0, round);
  endtask

  task automatic sweep(input int round, input int start, input int count);
    int pos = start;
    for (int n = 0; n < count; n++) begin
      step = 1'b1;
      data_in = data_in + 8'd29;
      @(negedge clk);
      step = 1'b0;
      pos = (pos + 1) % S;
      check_view((pos == 0) ? "R6 R3" : "R5 R3", pos, round);
      @(negedge clk);
      check_view("R5 hold", pos, round);
    end
  endtask

  initial begin
    int pos;
    // Round 0: plain capture, wrap sweeps.
    cur_round = 0;
    capture_round(0, 1'b0);
    sweep(0, 0, 2 * S + 1);
    // Multi-cycle step: advance once per high cycle.
    pos = (2 * S + 1) % S;
    step = 1'b1;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      pos = (pos + 1) % S;
      check_view("R7", pos, 0);
    end
    step = 1'b0;
    // Step and reset on the same edge.
    @(negedge clk);
    rst = 1'b1;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    check_idx("R9", 0);
    // Round 1: step held high during the whole capture window.
    cur_round = 1;
    capture_round(1, 1'b1);
    sweep(1, 0, S + 2);
    // Round 2: fresh data must replace every slot.
    cur_round = 2;
    capture_round(2, 1'b0);
    sweep(2, 0, S);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule